// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Unit

This block is the stack engine of a small 8-bit microcontroller core. It owns an 8-bit stack pointer and a 256-byte internal data RAM. Push and pop requests move one byte at a time. Call and return requests save and restore a 16-bit program counter as two bytes. The stack pointer starts at 07h and grows toward higher addresses, so the first byte pushed after reset lands at 08h.

The same RAM also serves ordinary direct accesses. Direct addresses 00h–7Fh reach the RAM. The upper half of direct space is special-register space, and the stack pointer is mapped there at address 81h. The RAM has a single port, so a direct access and a stack operation cannot use it in the same cycle. When both arrive together, the direct access wins and the stack operation runs one cycle later. While `busy_o` is high, the caller holds off new stack requests.

Top module: `stack_unit`

## Requirements
- R1: After reset, `sp_o` is 07h, and `busy_o`, `err_o`, `wrap_o`, `pop_valid_o` and `ret_valid_o` are all low.
- R2: A push increments the pointer and then writes the byte at the new pointer value, so the first push after reset stores at 08h. `sp_o` shows the new value one cycle after the request.
- R3: A pop reads the byte at the current pointer and then decrements the pointer. `pop_valid_o` and `pop_data_o` appear one cycle after the request, and bytes come back in last-in, first-out order.
- R4: A call takes two RAM cycles. The low program-counter byte is written at SP+1 and the high byte at SP+2. `busy_o` is high for the one cycle between the two writes.
- R5: A return reads the high byte at SP and then the low byte at SP-1. `ret_valid_o` and `ret_pc_o` appear two cycles after the request, and the pointer ends two below its start. `pop_valid_o` and `ret_valid_o` are never high together.
- R6: Direct address 81h is the stack pointer. A direct write loads `sp_o` one cycle later, and a direct read returns the pointer on `dir_rdata_o` one cycle later.
- R7: Direct addresses 00h–7Fh reach the RAM. Read data appears on `dir_rdata_o` one cycle after the read request. If `dir_we_i` and `dir_re_i` are both high, only the write is performed.
- R8: Direct addresses 80h–FFh other than 81h read as 00h. Writes to them leave the RAM and the pointer unchanged, including RAM bytes 80h–FFh, which only stack operations can reach.
- R9: The pointer wraps modulo 256 with no trap. `wrap_o` pulses for one cycle after an increment from FFh to 00h or a decrement from 00h to FFh, and at no other time.
- R10: If more than one of push, pop, call and return is requested in the same cycle, all of them are ignored, the pointer keeps its value, and `err_o` pulses one cycle later.
- R11: A direct access in the same cycle as a stack request wins the RAM. The stack operation is deferred by one cycle, `busy_o` is high during that cycle, and the deferred operation uses the pointer as it stands after any direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push one byte |
| pop_i | input | 1 | Pop one byte |
| push_data_i | input | 8 | Byte to push |
| call_i | input | 1 | Save a program counter |
| ret_i | input | 1 | Restore a program counter |
| call_pc_i | input | 16 | Program counter to save |
| dir_we_i | input | 1 | Direct write strobe |
| dir_re_i | input | 1 | Direct read strobe |
| dir_addr_i | input | 8 | Direct address |
| dir_wdata_i | input | 8 | Direct write data |
| dir_rdata_o | output | 8 | Direct read data, one cycle after the read |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | Pop result valid |
| ret_pc_o | output | 16 | Restored program counter |
| ret_valid_o | output | 1 | Return result valid |
| sp_o | output | 8 | Current stack pointer |
| busy_o | output | 1 | Multi-cycle or deferred operation in progress |
| wrap_o | output | 1 | Pointer wrap pulse |
| err_o | output | 1 | Conflicting stack request pulse |

## Verification
Each result has a fixed delay. A push or pop changes `sp_o`, and a pop delivers its byte, one cycle after the request. A call frees `busy_o` after two cycles, and a return delivers its program counter after two cycles. Each of these is one cycle later when a direct access defers the operation. The driver applies stimulus on the falling edge and samples at the falling edge that follows the cycle in which each result is due. Expected bytes and program counters go into queues. A monitor compares them whenever a valid strobe appears, so a deferred result is matched in order and is not missed.

// File: rtl/stack_unit_pkg.sv
package stack_unit_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_PUSH, OP_POP, OP_CALL, OP_RET, OP_CALL_HI, OP_RET_LO
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_CALL_HI, ST_RET_LO} st_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_POP, RD_RET_HI, RD_RET_LO, RD_DRAM, RD_DSFR
  } rd_e;

  typedef enum logic [1:0] {SP_HOLD, SP_INC, SP_DEC, SP_LOAD} sp_cmd_e;
endpackage

// File: rtl/stack_sp.sv
module stack_sp
  import stack_unit_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sp_cmd_e       cmd_i,
  input  logic [AW-1:0] load_i,
  output logic [AW-1:0] sp_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] SP_MAX = '1;

  logic [AW-1:0] sp_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= SP_RST;
      wrap_q <= 1'b0;
    end else begin
      unique case (cmd_i)
        SP_INC:  sp_q <= sp_q + 1'b1;
        SP_DEC:  sp_q <= sp_q - 1'b1;
        SP_LOAD: sp_q <= load_i;
        default: sp_q <= sp_q;
      endcase
      wrap_q <= (cmd_i == SP_INC && sp_q == SP_MAX) ||
                (cmd_i == SP_DEC && sp_q == '0);
    end
  end

  assign sp_o   = sp_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i)      mem_q[addr_i] <= wdata_i;
    else if (re_i) rdata_q       <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_unit_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] SFR_ADDR = 8'h81
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic [2*DW-1:0] call_pc_i,
  input  logic            dir_we_i,
  input  logic            dir_re_i,
  input  logic [AW-1:0]   dir_addr_i,
  input  logic [DW-1:0]   dir_wdata_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output sp_cmd_e         sp_cmd_o,
  output logic [AW-1:0]   sp_load_o,
  output logic            ram_we_o,
  output logic            ram_re_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic [DW-1:0]   dir_rdata_o,
  output logic [DW-1:0]   pop_data_o,
  output logic            pop_valid_o,
  output logic [2*DW-1:0] ret_pc_o,
  output logic            ret_valid_o,
  output logic            busy_o,
  output logic            err_o
);
  localparam int unsigned PCW = 2 * DW;

  st_e            st_q, st_d;
  op_e            pend_op_q, pend_op_d, req_op, run_op;
  logic [DW-1:0]  pend_data_q, pend_data_d, pc_hi_q, pc_hi_d;
  logic [PCW-1:0] pend_pc_q, pend_pc_d;
  rd_e            rd_q, rd_d;
  logic [DW-1:0]  ret_hi_q, sfr_q;
  logic           err_q, err_d;
  logic           dir_act, dir_ram, dir_sfr, multi_req;
  logic [DW-1:0]  op_data;
  logic [PCW-1:0] op_pc;
  logic [AW-1:0]  sp_plus;

  assign dir_act   = dir_we_i | dir_re_i;
  assign dir_ram   = ~dir_addr_i[AW-1];
  assign dir_sfr   = dir_addr_i == SFR_ADDR;
  assign multi_req = $countones({push_i, pop_i, call_i, ret_i}) > 1;
  assign sp_plus   = sp_i + 1'b1;
  assign op_data   = (st_q == ST_PEND) ? pend_data_q : push_data_i;
  assign op_pc     = (st_q == ST_PEND) ? pend_pc_q : call_pc_i;

  always_comb begin
    req_op = OP_NONE;
    if (!multi_req) begin
      if (push_i)      req_op = OP_PUSH;
      else if (pop_i)  req_op = OP_POP;
      else if (call_i) req_op = OP_CALL;
      else if (ret_i)  req_op = OP_RET;
    end
  end

  always_comb begin
    st_d        = st_q;
    pend_op_d   = pend_op_q;
    pend_data_d = pend_data_q;
    pend_pc_d   = pend_pc_q;
    pc_hi_d     = pc_hi_q;
    rd_d        = RD_NONE;
    err_d       = 1'b0;
    run_op      = OP_NONE;
    sp_cmd_o    = SP_HOLD;
    sp_load_o   = dir_wdata_i[AW-1:0];
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    ram_addr_o  = dir_addr_i;
    ram_wdata_o = dir_wdata_i;

    unique case (st_q)
      ST_IDLE: begin
        err_d = multi_req;
        if (dir_act && req_op != OP_NONE) begin
          st_d        = ST_PEND;
          pend_op_d   = req_op;
          pend_data_d = push_data_i;
          pend_pc_d   = call_pc_i;
        end else if (!dir_act) begin
          run_op = req_op;
        end
      end
      ST_PEND: if (!dir_act) begin
        run_op = pend_op_q;
        st_d   = ST_IDLE;
      end
      ST_CALL_HI: if (!dir_act) begin
        run_op = OP_CALL_HI;
        st_d   = ST_IDLE;
      end
      default: if (!dir_act) begin
        run_op = OP_RET_LO;
        st_d   = ST_IDLE;
      end
    endcase

    // direct port owns the RAM this cycle
    if (dir_we_i) begin
      if (dir_ram)      ram_we_o = 1'b1;
      else if (dir_sfr) sp_cmd_o = SP_LOAD;
    end else if (dir_re_i) begin
      if (dir_ram) begin
        ram_re_o = 1'b1;
        rd_d     = RD_DRAM;
      end else if (dir_sfr) begin
        rd_d = RD_DSFR;
      end
    end

    unique case (run_op)
      OP_PUSH, OP_CALL, OP_CALL_HI: begin
        sp_cmd_o   = SP_INC;
        ram_we_o   = 1'b1;
        ram_addr_o = sp_plus;
        if (run_op == OP_PUSH) ram_wdata_o = op_data;
        else if (run_op == OP_CALL) begin
          ram_wdata_o = op_pc[DW-1:0];
          pc_hi_d     = op_pc[PCW-1:DW];
          st_d        = ST_CALL_HI;
        end else ram_wdata_o = pc_hi_q;
      end
      OP_POP, OP_RET, OP_RET_LO: begin
        sp_cmd_o   = SP_DEC;
        ram_re_o   = 1'b1;
        ram_addr_o = sp_i;
        if (run_op == OP_POP) rd_d = RD_POP;
        else if (run_op == OP_RET) begin
          rd_d = RD_RET_HI;
          st_d = ST_RET_LO;
        end else rd_d = RD_RET_LO;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_op_q   <= OP_NONE;
      pend_data_q <= '0;
      pend_pc_q   <= '0;
      pc_hi_q     <= '0;
      rd_q        <= RD_NONE;
      ret_hi_q    <= '0;
      sfr_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_op_q   <= pend_op_d;
      pend_data_q <= pend_data_d;
      pend_pc_q   <= pend_pc_d;
      pc_hi_q     <= pc_hi_d;
      rd_q        <= rd_d;
      err_q       <= err_d;
      if (rd_q == RD_RET_HI) ret_hi_q <= ram_rdata_i;
      if (rd_d == RD_DSFR)   sfr_q    <= DW'(sp_i);
    end
  end

  assign pop_valid_o = rd_q == RD_POP;
  assign pop_data_o  = pop_valid_o ? ram_rdata_i : '0;
  assign ret_valid_o = rd_q == RD_RET_LO;
  assign ret_pc_o    = ret_valid_o ? {ret_hi_q, ram_rdata_i} : '0;
  assign dir_rdata_o = (rd_q == RD_DRAM) ? ram_rdata_i :
                       (rd_q == RD_DSFR) ? sfr_q : '0;
  assign busy_o      = st_q != ST_IDLE;
  assign err_o       = err_q;
endmodule

// File: rtl/stack_unit.sv
module stack_unit
  import stack_unit_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07,
  parameter logic [AW-1:0] SFR_ADDR = 8'h81
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [2*DW-1:0] call_pc_i,
  input  logic            dir_we_i,
  input  logic            dir_re_i,
  input  logic [AW-1:0]   dir_addr_i,
  input  logic [DW-1:0]   dir_wdata_i,
  output logic [DW-1:0]   dir_rdata_o,
  output logic [DW-1:0]   pop_data_o,
  output logic            pop_valid_o,
  output logic [2*DW-1:0] ret_pc_o,
  output logic            ret_valid_o,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            wrap_o,
  output logic            err_o
);
  sp_cmd_e       sp_cmd;
  logic [AW-1:0] sp_load, ram_addr;
  logic          ram_we, ram_re;
  logic [DW-1:0] ram_wdata, ram_rdata;

  stack_sp #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (sp_cmd),
    .load_i (sp_load),
    .sp_o   (sp_o),
    .wrap_o (wrap_o)
  );

  stack_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  stack_seq #(.AW(AW), .DW(DW), .SFR_ADDR(SFR_ADDR)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .push_data_i (push_data_i),
    .call_pc_i   (call_pc_i),
    .dir_we_i    (dir_we_i),
    .dir_re_i    (dir_re_i),
    .dir_addr_i  (dir_addr_i),
    .dir_wdata_i (dir_wdata_i),
    .sp_i        (sp_o),
    .ram_rdata_i (ram_rdata),
    .sp_cmd_o    (sp_cmd),
    .sp_load_o   (sp_load),
    .ram_we_o    (ram_we),
    .ram_re_o    (ram_re),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .dir_rdata_o (dir_rdata_o),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .ret_pc_o    (ret_pc_o),
    .ret_valid_o (ret_valid_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] SFR_ADDR = 8'h81
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          call_i,
  input logic          ret_i,
  input logic          dir_we_i,
  input logic          dir_re_i,
  input logic [AW-1:0] dir_addr_i,
  input logic [AW-1:0] dir_wdata_i,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          pop_valid_o,
  input logic          ret_valid_o,
  input logic          wrap_o,
  input logic          err_o
);
  logic quiet_dir;
  assign quiet_dir = !dir_we_i && !dir_re_i;

  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && quiet_dir && push_i && !pop_i && !call_i && !ret_i
    |=> sp_o == $past(sp_o) + 1'b1); // R2

  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && quiet_dir && pop_i && !push_i && !call_i && !ret_i
    |=> pop_valid_o && sp_o == $past(sp_o) - 1'b1); // R3

  AST_CALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && quiet_dir && call_i && !push_i && !pop_i && !ret_i
    |=> busy_o); // R4

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop_valid_o, ret_valid_o})); // R5

  AST_SP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && dir_addr_i == SFR_ADDR |=> sp_o == $past(dir_wdata_i)); // R6

  AST_WRAP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (sp_o == '0 || sp_o == '1)); // R9

  AST_CONFLICT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && quiet_dir && push_i && pop_i |=> err_o && $stable(sp_o)); // R10

  AST_DEFER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !quiet_dir && $countones({push_i, pop_i, call_i, ret_i}) == 1
    |=> busy_o); // R11
endmodule

bind stack_unit stack_unit_chk #(.AW(AW), .SFR_ADDR(SFR_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .dir_we_i    (dir_we_i),
  .dir_re_i    (dir_re_i),
  .dir_addr_i  (dir_addr_i),
  .dir_wdata_i (dir_wdata_i),
  .sp_o        (sp_o),
  .busy_o      (busy_o),
  .pop_valid_o (pop_valid_o),
  .ret_valid_o (ret_valid_o),
  .wrap_o      (wrap_o),
  .err_o       (err_o)
);

// File: tb/stack_unit_tb.sv
`timescale 1ns/1ps
module stack_unit_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0;
  logic        dir_we_i = 0, dir_re_i = 0;
  logic [7:0]  push_data_i = 0, dir_addr_i = 0, dir_wdata_i = 0;
  logic [15:0] call_pc_i = 0;
  logic [7:0]  dir_rdata_o, pop_data_o, sp_o;
  logic [15:0] ret_pc_o;
  logic        pop_valid_o, ret_valid_o, busy_o, wrap_o, err_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  m_sp;
  logic [7:0]  m_mem [256];
  logic [7:0]  exp_pop [$];
  logic [15:0] exp_ret [$];

  always #10 clk = ~clk;

  stack_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .call_i(call_i), .ret_i(ret_i),
    .call_pc_i(call_pc_i), .dir_we_i(dir_we_i), .dir_re_i(dir_re_i),
    .dir_addr_i(dir_addr_i), .dir_wdata_i(dir_wdata_i),
    .dir_rdata_o(dir_rdata_o), .pop_data_o(pop_data_o),
    .pop_valid_o(pop_valid_o), .ret_pc_o(ret_pc_o),
    .ret_valid_o(ret_valid_o), .sp_o(sp_o), .busy_o(busy_o),
    .wrap_o(wrap_o), .err_o(err_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compare results against queued expectations
  always @(negedge clk) if (rst_ni) begin
    if (pop_valid_o) begin
      if (exp_pop.size() == 0) chk("R3 unexpected pop", 16'(pop_data_o), 16'hxxxx);
      else chk("R3 pop data", 16'(pop_data_o), 16'(exp_pop.pop_front()));
    end
    if (ret_valid_o) begin
      if (exp_ret.size() == 0) chk("R5 unexpected ret", ret_pc_o, 16'hxxxx);
      else chk("R5 ret pc", ret_pc_o, exp_ret.pop_front());
    end
  end

  task automatic do_push(logic [7:0] d);
    push_i = 1; push_data_i = d; step(); push_i = 0;
    m_sp++; m_mem[m_sp] = d;
    chk("R2 sp after push", 16'(sp_o), 16'(m_sp));
  endtask

  task automatic do_pop();
    pop_i = 1; exp_pop.push_back(m_mem[m_sp]); m_sp--;
    step(); pop_i = 0;
    chk("R3 sp after pop", 16'(sp_o), 16'(m_sp));
  endtask

  task automatic do_call(logic [15:0] pc);
    call_i = 1; call_pc_i = pc; step(); call_i = 0;
    chk("R4 busy mid call", 16'(busy_o), 16'd1);
    step();
    m_mem[8'(m_sp + 1)] = pc[7:0]; m_mem[8'(m_sp + 2)] = pc[15:8]; m_sp += 2;
    chk("R4 busy after call", 16'(busy_o), 16'd0);
    chk("R4 sp after call", 16'(sp_o), 16'(m_sp));
  endtask

  task automatic do_ret();
    ret_i = 1; exp_ret.push_back({m_mem[m_sp], m_mem[8'(m_sp - 1)]});
    step(); ret_i = 0;
    chk("R5 busy mid ret", 16'(busy_o), 16'd1);
    step(); m_sp -= 2;
    chk("R5 sp after ret", 16'(sp_o), 16'(m_sp));
  endtask

  task automatic dread(logic [7:0] a, logic [7:0] exp, string tag);
    dir_re_i = 1; dir_addr_i = a; step(); dir_re_i = 0;
    chk(tag, 16'(dir_rdata_o), 16'(exp));
  endtask

  task automatic dwrite(logic [7:0] a, logic [7:0] d);
    dir_we_i = 1; dir_addr_i = a; dir_wdata_i = d; step(); dir_we_i = 0;
    if (a < 8'h80) m_mem[a] = d;
    else if (a == 8'h81) m_sp = d;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_sp = 8'h07;
    repeat (3) step();
    rst_ni = 1;
    step();
    chk("R1 reset sp", 16'(sp_o), 16'h0007);
    chk("R1 reset flags", 16'({busy_o, err_o, wrap_o, pop_valid_o, ret_valid_o}), 16'd0);

    do_push(8'hA1);
    dread(8'h08, 8'hA1, "R2 first push at 08h");
    do_push(8'hB2);
    do_push(8'hC3);
    do_pop(); do_pop();
    do_push(8'h5E);
    do_pop(); do_pop();
    chk("R3 sp back to reset", 16'(sp_o), 16'h0007);

    dread(8'h81, m_sp, "R6 read sp");
    dwrite(8'h81, 8'h30);
    chk("R6 sp loaded", 16'(sp_o), 16'h0030);
    dwrite(8'h20, 8'h6D);
    dread(8'h20, 8'h6D, "R7 direct ram");
    dir_we_i = 1; dir_re_i = 1; dir_addr_i = 8'h21; dir_wdata_i = 8'h77;
    step(); dir_we_i = 0; dir_re_i = 0; m_mem[8'h21] = 8'h77;
    dread(8'h21, 8'h77, "R7 write wins over read");

    do_call(16'h1234);
    dread(8'h31, 8'h34, "R4 low byte at sp+1");
    dread(8'h32, 8'h12, "R4 high byte at sp+2");
    do_call(16'hBEEF);
    do_ret();
    do_ret();

    // R8: unmapped upper direct space
    dwrite(8'h81, 8'h8F);
    do_push(8'hC3);
    dwrite(8'h90, 8'h11);
    dread(8'h90, 8'h00, "R8 unmapped reads zero");
    chk("R8 sp untouched", 16'(sp_o), 16'h0090);
    do_pop();

    // R9: wrap both ways
    dwrite(8'h81, 8'hFF);
    do_push(8'hAA);
    chk("R9 wrap on inc", 16'(wrap_o), 16'd1);
    step();
    chk("R9 wrap one cycle", 16'(wrap_o), 16'd0);
    dread(8'h00, 8'hAA, "R9 push wrapped to 00h");
    do_pop();
    chk("R9 wrap on dec", 16'(wrap_o), 16'd1);
    chk("R9 sp FFh", 16'(sp_o), 16'h00FF);

    // R10: conflicting requests
    dwrite(8'h81, 8'h40);
    push_i = 1; pop_i = 1; push_data_i = 8'h99; step(); push_i = 0; pop_i = 0;
    chk("R10 err pulse", 16'(err_o), 16'd1);
    chk("R10 sp kept", 16'(sp_o), 16'h0040);
    step();
    chk("R10 err clears", 16'(err_o), 16'd0);
    dread(8'h41, m_mem[8'h41], "R10 ram untouched");

    // R11: direct SP write collides with a push
    dir_we_i = 1; dir_addr_i = 8'h81; dir_wdata_i = 8'h50;
    push_i = 1; push_data_i = 8'h5A;
    step(); dir_we_i = 0; push_i = 0; m_sp = 8'h50;
    chk("R11 busy while deferred", 16'(busy_o), 16'd1);
    chk("R11 sp loaded first", 16'(sp_o), 16'h0050);
    step(); m_sp++; m_mem[m_sp] = 8'h5A;
    chk("R11 deferred push done", 16'(sp_o), 16'h0051);
    chk("R11 busy clear", 16'(busy_o), 16'd0);
    dread(8'h51, 8'h5A, "R11 deferred push data");

    // R11: direct read collides with a pop
    dir_re_i = 1; dir_addr_i = 8'h21; pop_i = 1;
    exp_pop.push_back(m_mem[m_sp]); m_sp--;
    step(); dir_re_i = 0; pop_i = 0;
    chk("R11 direct read first", 16'(dir_rdata_o), 16'h0077);
    chk("R11 pop held", 16'(pop_valid_o), 16'd0);
    step();
    chk("R11 deferred pop sp", 16'(sp_o), 16'(m_sp));

    step(); step();
    chk("R3 pop queue drained", 16'(exp_pop.size()), 16'd0);
    chk("R5 ret queue drained", 16'(exp_ret.size()), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule